// File: doc/BRIEF.md
# Audio Codec Controller Register Bank

This block is the software-visible register bank of an audio codec controller. It sits on a simple 32-bit word bus. It holds two groups of state. The first is a command path to the codec's internal registers: a control word, a codec register address, an outbound data word and an inbound data word. The second is a set of control, address and remaining-count words for two DMA channels, one for playback (down) and one for capture (up).

Software starts a codec register transaction by writing the control word with its request bit set. The block turns that write into a single-cycle pulse on one of two interrupt lines. The direction bit in the same write selects the line. The request bit itself is never stored. Each channel's enable bit leaves the block as a level. The stored codec and DMA words are also driven out as ports, so the serial link and the DMA engines can use them.

Bus accesses that are misaligned, that hit the reserved slot, or that fall past the last register have no effect. They read as zero and raise an error strobe. Read data is registered.

Top module: `aud_ctrl_regs`

## Requirements
- R1: While `rst_n` is low, every stored word, `bus_rdata`, `bus_err`, both interrupt lines and both enables are zero.
- R2: The register index is `bus_addr >> 2`. Index 1 is the codec address, 2 is data out, 3 is data in, 5 and 6 are down address and down count, and 9 and 10 are up address and up count. Each of these keeps all 32 written bits and reads them back unchanged. The matching output ports show the stored values.
- R3: A write to index 0 (codec control) stores the written value with bit 0 forced to zero.
- R4: A write to index 0 with bit 0 = 1 and bit 1 = 1 raises `codec_req_irq` in the cycle after the write edge, for exactly one cycle.
- R5: A write to index 0 with bit 0 = 1 and bit 1 = 0 raises `codec_reply_irq` the same way. A write with bit 0 = 0 raises neither line.
- R6: Bit 0 of index 4 (down control) drives `dn_en`, and bit 0 of index 8 (up control) drives `up_en`. Both are levels that change only when their own control word is written. The full control words read back.
- R7: An access with `bus_addr[1:0]` not zero, or to index 7, or to any index above 10, changes no register and reads as zero. It pulses `bus_err` for one cycle after the edge.
- R8: `bus_rdata` loads on the edge where `bus_rd` is sampled high and holds its value until the next read.
- R9: When `bus_rd` and `bus_wr` are both high in one cycle, the write takes effect and the read returns the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| bus_err | output | 1 | One-cycle strobe for an invalid access |
| codec_req_irq | output | 1 | Pulse: write-direction codec request |
| codec_reply_irq | output | 1 | Pulse: read-direction codec request |
| codec_addr | output | DATA_W | Stored codec register address |
| codec_dout | output | DATA_W | Stored outbound codec data |
| dn_en | output | 1 | Playback channel enable |
| dn_addr | output | DATA_W | Playback DMA address |
| dn_count | output | DATA_W | Playback remaining count |
| up_en | output | 1 | Capture channel enable |
| up_addr | output | DATA_W | Capture DMA address |
| up_count | output | DATA_W | Capture remaining count |

## Verification
A read and a write can land in the same cycle. The read must then return the word from before the write, while the write still updates the register. The bench provokes this by raising both strobes on the data-out index with a new value. It expects the old value on `bus_rdata`, then issues a plain read to confirm the new value was stored. It also makes sure that an interrupt pulse never lines up with an error strobe: every invalid access in the vector table checks that both interrupt lines stay low.

// File: rtl/aud_regs_pkg.sv
package aud_regs_pkg;
  localparam int unsigned NUM_WORDS   = 11;
  localparam int unsigned IDX_W       = 4;
  localparam int unsigned NUM_CHAN    = 2;
  localparam int unsigned CMD_SLOTS   = 4;
  localparam int unsigned CHAN_SLOTS  = 3;
  localparam int unsigned CHAN_BASE   = 4;
  localparam int unsigned CHAN_STRIDE = 4;
  localparam int unsigned RSV_IDX     = 7;
  localparam int unsigned GO_BIT      = 0;
  localparam int unsigned DIR_BIT     = 1;
  localparam int unsigned EN_BIT      = 0;
endpackage

// File: rtl/aud_addr_decode.sv
module aud_addr_decode
  import aud_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 rd,
  input  logic                 wr,
  output logic [IDX_W-1:0]     idx,
  output logic                 hit,
  output logic                 bad,
  output logic [NUM_WORDS-1:0] wr_sel
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              aligned;
  logic              in_range;

  assign word     = addr[ADDR_W-1:2];
  assign aligned  = (addr[1:0] == 2'b00);
  assign in_range = (32'(word) < NUM_WORDS);
  assign hit      = aligned && in_range && (32'(word) != RSV_IDX);
  assign idx      = IDX_W'(word);
  assign bad      = (rd || wr) && !hit;

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_sel
    assign wr_sel[g] = wr && hit && (32'(word) == g);
  end
endmodule

// File: rtl/aud_cmd_regs.sv
module aud_cmd_regs
  import aud_regs_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CMD_SLOTS-1:0] we,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    ctrl_q,
  output logic [DATA_W-1:0]    addr_q,
  output logic [DATA_W-1:0]    dout_q,
  output logic [DATA_W-1:0]    din_q,
  output logic                 req_irq,
  output logic                 reply_irq
);
  logic [DATA_W-1:0] ctrl_d, addr_d, dout_d, din_d;
  logic              req_d, reply_d;
  logic [DATA_W-1:0] go_mask;

  assign go_mask = ~(DATA_W'(1) << GO_BIT);

  always_comb begin
    ctrl_d  = ctrl_q;
    addr_d  = addr_q;
    dout_d  = dout_q;
    din_d   = din_q;
    if (we[0]) ctrl_d = wdata & go_mask;
    if (we[1]) addr_d = wdata;
    if (we[2]) dout_d = wdata;
    if (we[3]) din_d  = wdata;
    req_d   = we[0] && wdata[GO_BIT] &&  wdata[DIR_BIT];
    reply_d = we[0] && wdata[GO_BIT] && !wdata[DIR_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      addr_q    <= '0;
      dout_q    <= '0;
      din_q     <= '0;
      req_irq   <= 1'b0;
      reply_irq <= 1'b0;
    end else begin
      ctrl_q    <= ctrl_d;
      addr_q    <= addr_d;
      dout_q    <= dout_d;
      din_q     <= din_d;
      req_irq   <= req_d;
      reply_irq <= reply_d;
    end
  end

  // R5: the two pulse lines never fire together
  a_r5_irq_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_irq && reply_irq));
  // R4: a request pulse follows a control write carrying the request bit
  a_r4_req_cause: assert property (@(posedge clk) disable iff (!rst_n)
    req_irq |-> $past(we[0] && wdata[GO_BIT] && wdata[DIR_BIT]));
  // R3: the direction bit written is the one kept
  a_r3_dir_kept: assert property (@(posedge clk) disable iff (!rst_n)
    we[0] |=> (ctrl_q[DIR_BIT] == $past(wdata[DIR_BIT])));
endmodule

// File: rtl/aud_dma_chan.sv
module aud_dma_chan
  import aud_regs_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CHAN_SLOTS-1:0] we,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     ctrl_q,
  output logic [DATA_W-1:0]     addr_q,
  output logic [DATA_W-1:0]     count_q,
  output logic                  en
);
  logic [DATA_W-1:0] ctrl_d, addr_d, count_d;

  always_comb begin
    ctrl_d  = ctrl_q;
    addr_d  = addr_q;
    count_d = count_q;
    if (we[0]) ctrl_d  = wdata;
    if (we[1]) addr_d  = wdata;
    if (we[2]) count_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      addr_q  <= '0;
      count_q <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      addr_q  <= addr_d;
      count_q <= count_d;
    end
  end

  assign en = ctrl_q[EN_BIT];

  // R6: enable moves only on a write to its own control word
  a_r6_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(we[0]) |-> $stable(en));
  a_r6_en_follow: assert property (@(posedge clk) disable iff (!rst_n)
    we[0] |=> (en == $past(wdata[EN_BIT])));
endmodule

// File: rtl/aud_ctrl_regs.sv
module aud_ctrl_regs
  import aud_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  output logic              codec_req_irq,
  output logic              codec_reply_irq,
  output logic [DATA_W-1:0] codec_addr,
  output logic [DATA_W-1:0] codec_dout,
  output logic              dn_en,
  output logic [DATA_W-1:0] dn_addr,
  output logic [DATA_W-1:0] dn_count,
  output logic              up_en,
  output logic [DATA_W-1:0] up_addr,
  output logic [DATA_W-1:0] up_count
);
  logic [IDX_W-1:0]     idx;
  logic                 hit, bad;
  logic [NUM_WORDS-1:0] wr_sel;
  logic                 unused_rsv_sel;

  logic [DATA_W-1:0] cmd_ctrl, cmd_din;
  logic [NUM_CHAN-1:0][DATA_W-1:0] ch_ctrl, ch_addr, ch_count;
  logic [NUM_CHAN-1:0]             ch_en;
  logic [NUM_WORDS-1:0][DATA_W-1:0] words;

  logic [DATA_W-1:0] rdata_d;
  logic              err_d;

  aud_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr   (bus_addr),
    .rd     (bus_rd),
    .wr     (bus_wr),
    .idx    (idx),
    .hit    (hit),
    .bad    (bad),
    .wr_sel (wr_sel)
  );

  assign unused_rsv_sel = wr_sel[RSV_IDX];

  aud_cmd_regs #(.DATA_W(DATA_W)) u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (wr_sel[CMD_SLOTS-1:0]),
    .wdata     (bus_wdata),
    .ctrl_q    (cmd_ctrl),
    .addr_q    (codec_addr),
    .dout_q    (codec_dout),
    .din_q     (cmd_din),
    .req_irq   (codec_req_irq),
    .reply_irq (codec_reply_irq)
  );

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    localparam int unsigned BASE = CHAN_BASE + c * CHAN_STRIDE;
    aud_dma_chan #(.DATA_W(DATA_W)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (wr_sel[BASE +: CHAN_SLOTS]),
      .wdata   (bus_wdata),
      .ctrl_q  (ch_ctrl[c]),
      .addr_q  (ch_addr[c]),
      .count_q (ch_count[c]),
      .en      (ch_en[c])
    );
  end

  assign dn_en    = ch_en[0];
  assign dn_addr  = ch_addr[0];
  assign dn_count = ch_count[0];
  assign up_en    = ch_en[1];
  assign up_addr  = ch_addr[1];
  assign up_count = ch_count[1];

  always_comb begin
    words    = '0;
    words[0] = cmd_ctrl;
    words[1] = codec_addr;
    words[2] = codec_dout;
    words[3] = cmd_din;
    for (int c = 0; c < NUM_CHAN; c++) begin
      words[CHAN_BASE + c * CHAN_STRIDE + 0] = ch_ctrl[c];
      words[CHAN_BASE + c * CHAN_STRIDE + 1] = ch_addr[c];
      words[CHAN_BASE + c * CHAN_STRIDE + 2] = ch_count[c];
    end
  end

  always_comb begin
    rdata_d = bus_rdata;
    if (bus_rd) rdata_d = hit ? words[idx] : '0;
    err_d = bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_rdata <= rdata_d;
      bus_err   <= err_d;
    end
  end

  // R8: read data holds unless a read was sampled
  a_r8_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_rd) |-> $stable(bus_rdata));
  // R7: error strobe only follows an access
  a_r7_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_rd || bus_wr));
  // R7: an invalid access never produces a codec pulse
  a_r7_err_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> !(codec_req_irq || codec_reply_irq));
endmodule

// File: tb/sim_aud_ctrl_regs.sv
`timescale 1ns/100ps
module sim_aud_ctrl_regs;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_err, codec_req_irq, codec_reply_irq;
  logic [31:0] codec_addr, codec_dout, dn_addr, dn_count, up_addr, up_count;
  logic        dn_en, up_en;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  aud_ctrl_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .codec_req_irq(codec_req_irq),
    .codec_reply_irq(codec_reply_irq), .codec_addr(codec_addr),
    .codec_dout(codec_dout), .dn_en(dn_en), .dn_addr(dn_addr),
    .dn_count(dn_count), .up_en(up_en), .up_addr(up_addr), .up_count(up_count)
  );

  typedef struct packed {
    logic [7:0]  a;
    logic [31:0] d;
    logic [31:0] r;
    logic        q;
    logic        p;
    logic        e;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{8'h04, 32'hDEADBEEF, 32'hDEADBEEF, 1'b0, 1'b0, 1'b0}, // R2
    '{8'h08, 32'h12345678, 32'h12345678, 1'b0, 1'b0, 1'b0}, // R2
    '{8'h0C, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 1'b0, 1'b0}, // R2
    '{8'h14, 32'hA5A5A5A5, 32'hA5A5A5A5, 1'b0, 1'b0, 1'b0}, // R2
    '{8'h18, 32'h00010000, 32'h00010000, 1'b0, 1'b0, 1'b0}, // R2
    '{8'h24, 32'h5A5A5A5A, 32'h5A5A5A5A, 1'b0, 1'b0, 1'b0}, // R2
    '{8'h28, 32'h80000001, 32'h80000001, 1'b0, 1'b0, 1'b0}, // R2
    '{8'h00, 32'h00000003, 32'h00000002, 1'b1, 1'b0, 1'b0}, // R3 R4
    '{8'h00, 32'h00000001, 32'h00000000, 1'b0, 1'b1, 1'b0}, // R3 R5
    '{8'h00, 32'hF0F0F0F2, 32'hF0F0F0F2, 1'b0, 1'b0, 1'b0}, // R5 no pulse
    '{8'h00, 32'h0000FFFF, 32'h0000FFFE, 1'b1, 1'b0, 1'b0}, // R3 R4
    '{8'h1C, 32'h11111111, 32'h00000000, 1'b0, 1'b0, 1'b1}, // R7 reserved
    '{8'h2C, 32'h22222222, 32'h00000000, 1'b0, 1'b0, 1'b1}, // R7 past end
    '{8'h06, 32'h33333333, 32'h00000000, 1'b0, 1'b0, 1'b1}, // R7 misaligned
    '{8'h10, 32'h00000001, 32'h00000001, 1'b0, 1'b0, 1'b0}, // R6
    '{8'h20, 32'h00000003, 32'h00000003, 1'b0, 1'b0, 1'b0}  // R6
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic bus_cycle(input logic [7:0] a, input logic [31:0] d,
                           input logic w, input logic r);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = w; bus_rd = r;
    @(posedge clk);
    #1;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic strobe(input logic [7:0] a, input logic [31:0] d,
                        input logic w, input logic r);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = w; bus_rd = r;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 rdata", bus_rdata, 0);
    chk("R1 err/irq/en", {28'd0, bus_err, codec_req_irq, codec_reply_irq, dn_en | up_en}, 0);
    chk("R1 codec_addr", codec_addr, 0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      strobe(VECS[i].a, VECS[i].d, 1'b1, 1'b0);
      chk($sformatf("R4 R5 R7 v%0d pulses", i),
          {29'd0, codec_req_irq, codec_reply_irq, bus_err},
          {29'd0, VECS[i].q, VECS[i].p, VECS[i].e});
      idle();
      @(posedge clk); #1;
      chk($sformatf("R4 R5 R7 v%0d one cycle", i),
          {29'd0, codec_req_irq, codec_reply_irq, bus_err}, 0);
      strobe(VECS[i].a, 32'h0, 1'b0, 1'b1);
      chk($sformatf("R2 R3 R7 v%0d readback", i), bus_rdata, VECS[i].r);
      chk($sformatf("R7 v%0d read err", i), {31'd0, bus_err}, {31'd0, VECS[i].e});
      idle();
    end

    // R2 exposed ports
    chk("R2 codec_addr", codec_addr, 32'hDEADBEEF);
    chk("R2 codec_dout", codec_dout, 32'h12345678);
    chk("R2 dn_addr", dn_addr, 32'hA5A5A5A5);
    chk("R2 dn_count", dn_count, 32'h00010000);
    chk("R2 up_addr", up_addr, 32'h5A5A5A5A);
    chk("R2 up_count", up_count, 32'h80000001);
    // R7 misaligned write to 0x06 left index 1 alone
    strobe(8'h04, 0, 1'b0, 1'b1);
    chk("R7 index1 untouched", bus_rdata, 32'hDEADBEEF);
    idle();

    // R6 enables
    chk("R6 enables on", {30'd0, dn_en, up_en}, 3);
    bus_cycle(8'h10, 32'hFFFFFFFE, 1'b1, 1'b0);
    chk("R6 down off, up kept", {30'd0, dn_en, up_en}, 1);
    bus_cycle(8'h20, 32'h00000002, 1'b1, 1'b0);
    chk("R6 up off", {30'd0, dn_en, up_en}, 0);

    // R8 hold
    strobe(8'h0C, 0, 1'b0, 1'b1);
    chk("R8 read", bus_rdata, 32'hFFFFFFFF);
    idle();
    repeat (3) @(posedge clk);
    #1;
    chk("R8 hold idle", bus_rdata, 32'hFFFFFFFF);
    bus_cycle(8'h04, 32'h01020304, 1'b1, 1'b0);
    chk("R8 hold across write", bus_rdata, 32'hFFFFFFFF);

    // R9 same-cycle read and write
    strobe(8'h08, 32'h0BADF00D, 1'b1, 1'b1);
    chk("R9 old value read", bus_rdata, 32'h12345678);
    idle();
    strobe(8'h08, 0, 1'b0, 1'b1);
    chk("R9 new value stored", bus_rdata, 32'h0BADF00D);
    idle();

    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    #1;
    chk("R1 async clear rdata", bus_rdata, 0);
    chk("R1 async clear codec_dout", codec_dout, 0);
    @(negedge clk); rst_n = 1'b1;
    strobe(8'h04, 0, 1'b0, 1'b1);
    chk("R1 codec addr zero after reset", bus_rdata, 0);
    idle();

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule